// File: doc/BRIEF.md
# SD Command Launcher with Response Capture

This block sits in an SD host between a register port and the logic that talks to the card. Software loads a command argument and then writes a 16-bit command word. If that word has its launch flag set, the block raises a request that carries the 6-bit command index and the argument. The request goes to a card-side responder, which is kept abstract here.

The responder later returns one pulse. The pulse carries a length code, an error indication and up to sixteen response bytes. The block checks the length against the response type that was asked for. A good response is packed into four 32-bit response words. A failed one sets a fail flag in the command word and a timeout flag in the status register.

When the command finishes, the block pulses a start signal for any data transfer that the command word requested. The card clock, CRC, line serialisation and real timeout counting live elsewhere.

Top module: `sdc_cmd_launcher`

## Requirements
- R1: After reset the command, argument, status and four response words read 0, and no request is raised.
- R2: A command-register write (address 0) with bit 15 set raises `req_valid` with `req_index` equal to bits 5:0 and `req_arg` equal to the argument register (address 1). The request and its fields hold steady until `req_ready` is seen high.
- R3: Bit 15 of the command word reads 1 from the launching write until the response pulse is taken, and reads 0 afterwards.
- R4: A command write with bit 15 clear only stores the word and raises no request. Bit 14 (fail) cannot be set by software: writes store it as 0.
- R5: The length code is 0 for none, 1 for 4 bytes, 2 for 16 bytes and 3 for any other length. Bytes arrive on `rsp_bytes`, with byte k at bits 8k+7:8k. A good 4-byte response sets word 0 (address 4) to {b0,b1,b2,b3}, with b0 most significant, and clears words 1 to 3 (addresses 5 to 7).
- R6: A good 16-byte response sets word 0 to {b12..b15}, word 1 to {b8..b11}, word 2 to {b4..b7} and word 3 to {b0..b3}, each with the lowest-numbered byte most significant.
- R7: When bit 10 (no response) is clear, each of the following is an error: a length code of 0 or 3, or a code of 1 while bit 9 (long) is set. On an error the response words keep their values, command bit 14 is set and status bit 6 (address 2) is set.
- R8: `rsp_err` high is an error even when bit 10 is set.
- R9: A command with bit 10 set that ends without error leaves the response words and the fail bit unchanged.
- R10: While a command is pending, writes to the command and argument registers are ignored.
- R11: Writing 1 to status bit 6 clears it. A new launch clears the fail bit.
- R12: If bit 6 (read) or bit 7 (write) is set, `data_go` pulses for one cycle, the cycle after the response is taken. `data_is_write` reflects bit 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register word address for reads and writes |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data for `reg_addr`, combinational |
| req_valid | output | 1 | Command request to the responder |
| req_ready | input | 1 | Responder takes the request |
| req_index | output | IDX_W | Command index |
| req_arg | output | ARG_W | Command argument |
| rsp_valid | input | 1 | One-cycle response pulse |
| rsp_err | input | 1 | Responder reports failure |
| rsp_len | input | 2 | Length code (see R5) |
| rsp_bytes | input | 32*RSP_WORDS | Response bytes, byte k at 8k+7:8k |
| data_go | output | 1 | Data transfer start pulse |
| data_is_write | output | 1 | Transfer direction, 1 for write |

## Verification
The bench builds the block with its default parameters: four 32-bit response words, a 32-bit argument and a 4-bit address with the response words at addresses 4 to 7. With these values both the 4-byte and 16-byte packing orders can be seen at the register port. Each response word can be loaded with a distinct byte pattern, so a swapped word or byte shows up as a wrong value. Word 0 also keeps a known value, which makes it possible to see that a failed or response-less command leaves it alone.

// File: rtl/sdc_pkg.sv
package sdc_pkg;
   localparam int CMD_W     = 16;
   localparam int CB_RD     = 6;
   localparam int CB_WR     = 7;
   localparam int CB_LONG   = 9;
   localparam int CB_NORSP  = 10;
   localparam int CB_BUSY   = 11;
   localparam int CB_FAIL   = 14;
   localparam int CB_NEW    = 15;
   localparam int ST_W      = 16;
   localparam int ST_TOUT   = 6;
   localparam int BYTES_PER_WORD = 4;

   typedef enum logic [1:0] {
      LEN_NONE  = 2'd0,
      LEN_SHORT = 2'd1,
      LEN_LONG  = 2'd2,
      LEN_BAD   = 2'd3
   } rsp_len_e;

   typedef enum logic [1:0] {
      PH_IDLE = 2'd0,
      PH_REQ  = 2'd1,
      PH_WAIT = 2'd2
   } phase_e;
endpackage

// File: rtl/sdc_rsp_check.sv
module sdc_rsp_check
   import sdc_pkg::*;
(
   input  logic       rsp_err,
   input  logic [1:0] rsp_len,
   input  logic       want_none,
   input  logic       want_long,
   output logic       bad
);
   logic len_bad;

   always_comb begin
      len_bad = 1'b0;
      unique case (rsp_len)
         LEN_NONE:  len_bad = 1'b1;
         LEN_SHORT: len_bad = want_long;
         LEN_LONG:  len_bad = 1'b0;
         default:   len_bad = 1'b1;
      endcase
      bad = rsp_err | (!want_none & len_bad);
   end
endmodule

// File: rtl/sdc_rsp_pack.sv
module sdc_rsp_pack
   import sdc_pkg::*;
#(
   parameter int RSP_WORDS = 4,
   parameter int WORD_W    = 32
) (
   input  logic [RSP_WORDS*WORD_W-1:0] bytes_in,
   input  logic                        is_long,
   output logic [RSP_WORDS*WORD_W-1:0] words_out
);
   localparam int BPW = WORD_W / 8;

   if (BPW != BYTES_PER_WORD) begin : g_bad_word
      $error("sdc_rsp_pack: WORD_W must hold four bytes");
   end

   for (genvar w = 0; w < RSP_WORDS; w++) begin : g_word
      localparam int LBASE = (RSP_WORDS - 1 - w) * BPW;
      logic [WORD_W-1:0] long_w;
      logic [WORD_W-1:0] short_w;

      for (genvar b = 0; b < BPW; b++) begin : g_byte
         localparam int HI = WORD_W - 1 - 8*b;
         assign long_w[HI -: 8] = bytes_in[8*(LBASE + b) +: 8];
         if (w == 0) begin : g_s0
            assign short_w[HI -: 8] = bytes_in[8*b +: 8];
         end else begin : g_sz
            assign short_w[HI -: 8] = 8'h00;
         end
      end

      assign words_out[w*WORD_W +: WORD_W] = is_long ? long_w : short_w;
   end
endmodule

// File: rtl/sdc_issue_seq.sv
module sdc_issue_seq
   import sdc_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic launch,
   input  logic req_ready,
   input  logic rsp_valid,
   output logic req_valid,
   output logic accept,
   output logic pending
);
   phase_e ph_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ph_q <= PH_IDLE;
      end else begin
         unique case (ph_q)
            PH_IDLE: if (launch)    ph_q <= PH_REQ;
            PH_REQ:  if (req_ready) ph_q <= PH_WAIT;
            PH_WAIT: if (rsp_valid) ph_q <= PH_IDLE;
            default:                ph_q <= PH_IDLE;
         endcase
      end
   end

   assign req_valid = (ph_q == PH_REQ);
   assign accept    = (ph_q == PH_WAIT) && rsp_valid;
   assign pending   = (ph_q != PH_IDLE);
endmodule

// File: rtl/sdc_cmd_launcher.sv
module sdc_cmd_launcher
   import sdc_pkg::*;
#(
   parameter int ADDR_W    = 4,
   parameter int DATA_W    = 32,
   parameter int ARG_W     = 32,
   parameter int IDX_W     = 6,
   parameter int RSP_WORDS = 4,
   parameter int RSP_BASE  = 4
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      reg_wr_en,
   input  logic [ADDR_W-1:0]         reg_addr,
   input  logic [DATA_W-1:0]         reg_wdata,
   output logic [DATA_W-1:0]         reg_rdata,
   output logic                      req_valid,
   input  logic                      req_ready,
   output logic [IDX_W-1:0]          req_index,
   output logic [ARG_W-1:0]          req_arg,
   input  logic                      rsp_valid,
   input  logic                      rsp_err,
   input  logic [1:0]                rsp_len,
   input  logic [32*RSP_WORDS-1:0]   rsp_bytes,
   output logic                      data_go,
   output logic                      data_is_write
);
   localparam int WORD_W   = 32;
   localparam int RSP_BITS = WORD_W * RSP_WORDS;
   localparam logic [ADDR_W-1:0] A_CMD = ADDR_W'(0);
   localparam logic [ADDR_W-1:0] A_ARG = ADDR_W'(1);
   localparam logic [ADDR_W-1:0] A_ST  = ADDR_W'(2);

   if (DATA_W < CMD_W || DATA_W < ARG_W || DATA_W < WORD_W) begin : g_bad_dw
      $error("sdc_cmd_launcher: DATA_W too narrow");
   end
   if (IDX_W < 1 || IDX_W > CB_RD) begin : g_bad_idx
      $error("sdc_cmd_launcher: IDX_W must fit below the read bit");
   end
   if (RSP_WORDS < 2) begin : g_bad_rw
      $error("sdc_cmd_launcher: need at least two response words");
   end
   if (RSP_BASE < 3 || RSP_BASE + RSP_WORDS > (1 << ADDR_W)) begin : g_bad_map
      $error("sdc_cmd_launcher: response words do not fit the address space");
   end

   logic [CMD_W-1:0]    cmd_q;
   logic [ARG_W-1:0]    arg_q;
   logic [ST_W-1:0]     status_q;
   logic [RSP_BITS-1:0] rsp_q;
   logic [RSP_BITS-1:0] packed_w;
   logic                go_q;
   logic                pending;
   logic                accept;
   logic                bad;
   logic                launch;
   logic                wr_free;

   assign wr_free = reg_wr_en && !pending;
   assign launch  = wr_free && (reg_addr == A_CMD) && reg_wdata[CB_NEW];

   sdc_issue_seq u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .launch    (launch),
      .req_ready (req_ready),
      .rsp_valid (rsp_valid),
      .req_valid (req_valid),
      .accept    (accept),
      .pending   (pending)
   );

   sdc_rsp_check u_chkl (
      .rsp_err   (rsp_err),
      .rsp_len   (rsp_len),
      .want_none (cmd_q[CB_NORSP]),
      .want_long (cmd_q[CB_LONG]),
      .bad       (bad)
   );

   sdc_rsp_pack #(.RSP_WORDS(RSP_WORDS), .WORD_W(WORD_W)) u_pack (
      .bytes_in  (rsp_bytes),
      .is_long   (rsp_len == LEN_LONG),
      .words_out (packed_w)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cmd_q    <= '0;
         arg_q    <= '0;
         status_q <= '0;
         rsp_q    <= '0;
         go_q     <= 1'b0;
      end else begin
         go_q <= accept && (cmd_q[CB_RD] || cmd_q[CB_WR]);
         if (wr_free && reg_addr == A_CMD) begin
            cmd_q          <= reg_wdata[CMD_W-1:0];
            cmd_q[CB_FAIL] <= 1'b0;
         end
         if (wr_free && reg_addr == A_ARG) begin
            arg_q <= reg_wdata[ARG_W-1:0];
         end
         if (reg_wr_en && reg_addr == A_ST && reg_wdata[ST_TOUT]) begin
            status_q[ST_TOUT] <= 1'b0;
         end
         if (accept) begin
            cmd_q[CB_NEW] <= 1'b0;
            if (bad) begin
               cmd_q[CB_FAIL]    <= 1'b1;
               status_q[ST_TOUT] <= 1'b1;
            end else if (!cmd_q[CB_NORSP]) begin
               rsp_q <= packed_w;
            end
         end
      end
   end

   always_comb begin
      reg_rdata = '0;
      if (reg_addr == A_CMD) begin
         reg_rdata = DATA_W'(cmd_q);
      end else if (reg_addr == A_ARG) begin
         reg_rdata = DATA_W'(arg_q);
      end else if (reg_addr == A_ST) begin
         reg_rdata = DATA_W'(status_q);
      end else begin
         for (int w = 0; w < RSP_WORDS; w++) begin
            if (reg_addr == ADDR_W'(RSP_BASE + w)) begin
               reg_rdata = DATA_W'(rsp_q[w*WORD_W +: WORD_W]);
            end
         end
      end
   end

   assign req_index     = cmd_q[IDX_W-1:0];
   assign req_arg       = arg_q;
   assign data_go       = go_q;
   assign data_is_write = cmd_q[CB_WR];
endmodule

// File: rtl/sdc_cmd_chk.sv
module sdc_cmd_chk
   import sdc_pkg::*;
#(
   parameter int ARG_W = 32,
   parameter int IDX_W = 6
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_valid,
   input logic              req_ready,
   input logic [IDX_W-1:0]  req_index,
   input logic [ARG_W-1:0]  req_arg,
   input logic              pending,
   input logic              accept,
   input logic [CMD_W-1:0]  cmd_q,
   input logic [ST_W-1:0]   status_q,
   input logic              data_go
);
   a_r2_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && !req_ready |=> req_valid && $stable(req_index) && $stable(req_arg));

   a_r2_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !pending |-> !req_valid);

   a_r3_new_clears: assert property (@(posedge clk) disable iff (!rst_n)
      accept |=> !cmd_q[CB_NEW]);

   a_r7_fail_with_timeout: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cmd_q[CB_FAIL]) |-> status_q[ST_TOUT]);

   a_r10_cmd_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      pending && !accept |=> $stable(cmd_q));

   a_r12_go_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
      data_go |-> $past(accept));
endmodule

bind sdc_cmd_launcher sdc_cmd_chk #(.ARG_W(ARG_W), .IDX_W(IDX_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .req_valid (req_valid),
   .req_ready (req_ready),
   .req_index (req_index),
   .req_arg   (req_arg),
   .pending   (pending),
   .accept    (accept),
   .cmd_q     (cmd_q),
   .status_q  (status_q),
   .data_go   (data_go)
);

// File: tb/sim_sdc_cmd_launcher.sv
module sim_sdc_cmd_launcher;
   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         reg_wr_en = 1'b0;
   logic [3:0]   reg_addr = '0;
   logic [31:0]  reg_wdata = '0;
   logic [31:0]  reg_rdata;
   logic         req_valid;
   logic         req_ready = 1'b0;
   logic [5:0]   req_index;
   logic [31:0]  req_arg;
   logic         rsp_valid = 1'b0;
   logic         rsp_err = 1'b0;
   logic [1:0]   rsp_len = '0;
   logic [127:0] rsp_bytes = '0;
   logic         data_go;
   logic         data_is_write;

   int checks = 0;
   int failures = 0;
   bit done = 0;

   always #10 clk = ~clk;

   sdc_cmd_launcher u0 (.*);

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [3:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_wr_en = 1'b0;
   endtask

   task automatic rd_chk(input logic [3:0] a, input logic [31:0] exp, input string tag);
      reg_addr = a;
      #1;
      chk(reg_rdata === exp, tag, reg_rdata, exp);
   endtask

   task automatic take_req;
      while (!req_valid) @(negedge clk);
      req_ready = 1'b1;
      @(negedge clk);
      req_ready = 1'b0;
   endtask

   task automatic respond(input logic [1:0] len, input logic err, input logic [127:0] b);
      @(negedge clk);
      rsp_valid = 1'b1; rsp_len = len; rsp_err = err; rsp_bytes = b;
      @(negedge clk);
      rsp_valid = 1'b0; rsp_err = 1'b0;
   endtask

   function automatic logic [127:0] ramp(input logic [7:0] base);
      logic [127:0] v;
      for (int k = 0; k < 16; k++) v[8*k +: 8] = base + 8'(k);
      return v;
   endfunction

   task automatic run_cmd(input logic [15:0] c, input logic [1:0] len, input logic err, input logic [127:0] b);
      wr(4'd0, {16'h0, c});
      take_req();
      respond(len, err, b);
   endtask

   task automatic t_reset;
      @(negedge clk);
      rd_chk(4'd0, 32'h0, "R1 cmd");
      rd_chk(4'd1, 32'h0, "R1 arg");
      rd_chk(4'd2, 32'h0, "R1 status");
      for (int w = 0; w < 4; w++) rd_chk(4'(4 + w), 32'h0, "R1 rsp");
      chk(req_valid == 1'b0, "R1 req_valid", 32'(req_valid), 32'h0);
   endtask

   task automatic t_plain_write;
      wr(4'd0, 32'h0000_4041);
      @(negedge clk);
      chk(req_valid == 1'b0, "R4 no request", 32'(req_valid), 32'h0);
      rd_chk(4'd0, 32'h0000_0041, "R4 stored, fail not writable");
   endtask

   task automatic t_issue_long;
      wr(4'd1, 32'h1234_5678);
      wr(4'd0, 32'h0000_8202);
      chk(req_valid == 1'b1, "R2 req_valid", 32'(req_valid), 32'h1);
      chk(req_index == 6'd2, "R2 index", 32'(req_index), 32'd2);
      chk(req_arg == 32'h1234_5678, "R2 arg", req_arg, 32'h1234_5678);
      @(negedge clk); @(negedge clk);
      chk(req_valid == 1'b1 && req_index == 6'd2, "R2 hold without ready", 32'(req_valid), 32'h1);
      rd_chk(4'd0, 32'h0000_8202, "R3 new reads 1 while pending");
      take_req();
      respond(2'd2, 1'b0, ramp(8'h10));
      rd_chk(4'd0, 32'h0000_0202, "R3 new cleared");
      rd_chk(4'd4, 32'h1C1D_1E1F, "R6 word0");
      rd_chk(4'd5, 32'h1819_1A1B, "R6 word1");
      rd_chk(4'd6, 32'h1415_1617, "R6 word2");
      rd_chk(4'd7, 32'h1011_1213, "R6 word3");
   endtask

   task automatic t_short;
      logic [127:0] b = ramp(8'h60);
      b[31:0] = 32'hD4C3_B2A1;
      run_cmd(16'h8011, 2'd1, 1'b0, b);
      chk(data_go == 1'b0, "R12 no go without transfer", 32'(data_go), 32'h0);
      rd_chk(4'd4, 32'hA1B2_C3D4, "R5 word0");
      rd_chk(4'd5, 32'h0, "R5 word1 cleared");
      rd_chk(4'd6, 32'h0, "R5 word2 cleared");
      rd_chk(4'd7, 32'h0, "R5 word3 cleared");
      rd_chk(4'd0, 32'h0000_0011, "R5 no fail");
   endtask

   task automatic t_bad_len;
      run_cmd(16'h8011, 2'd0, 1'b0, ramp(8'h80));
      rd_chk(4'd0, 32'h0000_4011, "R7 missing response fail");
      rd_chk(4'd2, 32'h0000_0040, "R7 timeout flag");
      rd_chk(4'd4, 32'hA1B2_C3D4, "R7 word0 kept");
      wr(4'd2, 32'h0000_0040);
      rd_chk(4'd2, 32'h0, "R11 timeout cleared");
      run_cmd(16'h8203, 2'd1, 1'b0, ramp(8'h90));
      rd_chk(4'd0, 32'h0000_4203, "R7 short for long fail");
      rd_chk(4'd4, 32'hA1B2_C3D4, "R7 word0 kept on short-for-long");
      wr(4'd2, 32'h0000_0040);
      run_cmd(16'h8011, 2'd3, 1'b0, ramp(8'hA0));
      rd_chk(4'd0, 32'h0000_4011, "R7 odd length fail");
      rd_chk(4'd2, 32'h0000_0040, "R7 odd length timeout");
      wr(4'd2, 32'h0000_0040);
      wr(4'd0, 32'h0000_8011);
      rd_chk(4'd0, 32'h0000_8011, "R11 launch clears fail");
      take_req();
      respond(2'd1, 1'b0, b_keep());
   endtask

   function automatic logic [127:0] b_keep();
      logic [127:0] v = '0;
      v[31:0] = 32'hD4C3_B2A1;
      return v;
   endfunction

   task automatic t_noresp;
      run_cmd(16'h8405, 2'd0, 1'b1, '0);
      rd_chk(4'd0, 32'h0000_4405, "R8 responder error fails");
      rd_chk(4'd2, 32'h0000_0040, "R8 timeout flag");
      wr(4'd2, 32'h0000_0040);
      run_cmd(16'h8400, 2'd2, 1'b0, ramp(8'hC0));
      rd_chk(4'd0, 32'h0000_0400, "R9 no fail");
      rd_chk(4'd4, 32'hA1B2_C3D4, "R9 word0 unchanged");
      rd_chk(4'd2, 32'h0, "R9 status clear");
   endtask

   task automatic t_ignore_pending;
      wr(4'd1, 32'hCAFE_0001);
      wr(4'd0, 32'h0000_8011);
      wr(4'd0, 32'h0000_0003);
      wr(4'd1, 32'hDEAD_BEEF);
      rd_chk(4'd0, 32'h0000_8011, "R10 cmd write ignored");
      chk(req_arg == 32'hCAFE_0001, "R10 arg write ignored", req_arg, 32'hCAFE_0001);
      rd_chk(4'd1, 32'hCAFE_0001, "R10 arg reg unchanged");
      take_req();
      respond(2'd1, 1'b0, b_keep());
   endtask

   task automatic t_data_go;
      run_cmd(16'h8098, 2'd1, 1'b0, b_keep());
      chk(data_go == 1'b1, "R12 go pulse", 32'(data_go), 32'h1);
      chk(data_is_write == 1'b1, "R12 write direction", 32'(data_is_write), 32'h1);
      @(negedge clk);
      chk(data_go == 1'b0, "R12 go one cycle", 32'(data_go), 32'h0);
      run_cmd(16'h8058, 2'd1, 1'b0, b_keep());
      chk(data_go == 1'b1 && data_is_write == 1'b0, "R12 read go", {30'h0, data_go, data_is_write}, 32'h2);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_plain_write();
      t_issue_long();
      t_short();
      t_bad_len();
      t_noresp();
      t_ignore_pending();
      t_data_go();
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         failures++;
         $display("FAIL watchdog actual=%h expected=%h", 32'h0, 32'h1);
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule